// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Sequencer

This block runs complete commands on a three-wire serial EEPROM that stores 16-bit words, so that no software has to toggle the pins one by one. A host presents a command code, a word address, write data and an address-length select, and pulses `cmd_valid` while `cmd_ready` is high. The sequencer raises chip select, shifts the command frame out most significant bit first, gathers the returned word on reads, observes the program-time hold after writes, and ends with a one-cycle `done` pulse.

The serial clock is produced by a prescaler. Each half-period lasts `half_div` system clocks, with a floor of `MIN_HALF` so that the pin rate can never exceed the device limit. The clock pin is shared with another function, so `pin_own` stays high for the whole transaction. A one-cycle `ant_restore` pulse at the end tells that function to put its own setting back on the pin.

Top module: `uw_eeprom_seq`

## Requirements
- R1: While reset is held and just after it, `ee_cs`, `ee_sk`, `ee_di`, `pin_own`, `done` and `ant_restore` are low, `cmd_ready` is high and `rd_data` is zero.
- R2: A command is accepted when `cmd_valid` is high and `cmd_ready` is high. From the next cycle `ee_cs` and `pin_own` are high with `ee_sk` and `ee_di` low. The first rising edge of `ee_sk` comes two half-periods after chip select rises. `ee_sk` is only ever high while `ee_cs` is high.
- R3: Command code 0 (read) sends the bits 1,1,0, then the address MSB first, then 16 clocks with `ee_di` low. The total is 3 + address-length rising edges of `ee_sk`, plus 16.
- R4: Command code 1 (write) sends the bits 1,0,1, then the address MSB first, then `cmd_wdata` MSB first (bit 15 first).
- R5: Command code 2 (write-enable) sends 1,0,0,1,1. Command code 3 (write-disable) sends 1,0,0,0,0. Both are followed by six zero bits, giving 11 clocks in total whatever the address length.
- R6: With `addr_long`=1 the address is 8 bits (`cmd_addr[7:0]`). With `addr_long`=0 it is 6 bits (`cmd_addr[5:0]`), and `cmd_addr[7:6]` has no effect on the pins.
- R7: Every high phase and every low phase of `ee_sk` inside a frame lasts E system clocks, where E = max(`half_div`, `MIN_HALF`), latched when the command is accepted. Chip select falls E clocks after the last falling edge of `ee_sk`.
- R8: During a read, `ee_do` is sampled at each rising edge of `ee_sk`. The last 16 samples, the first sample being bit 15, appear on `rd_data` in the cycle `done` is high.
- R9: After a write, `done` rises exactly `WRITE_HOLD` clocks after chip select falls. For the other commands `done` rises in the same cycle as chip select falls.
- R10: `done` is a one-cycle pulse. `ant_restore` pulses with it, `pin_own` is low from that cycle on, and `cmd_ready` is high again.
- R11: Write, write-enable and write-disable commands leave `rd_data` unchanged.
- R12: `cmd_valid` while a command is running has no effect. The running frame is not altered and no second command starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 read, 1 write, 2 write-enable, 3 write-disable |
| cmd_addr | input | 8 | Word address (upper two bits unused in 6-bit mode) |
| cmd_wdata | input | 16 | Word to write |
| addr_long | input | 1 | 1: 8-bit address, 0: 6-bit address |
| half_div | input | DIV_W | Serial clock half-period in system clocks |
| cmd_ready | output | 1 | Idle and able to accept a command |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock (shared pin) |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| rd_data | output | 16 | Last word read |
| done | output | 1 | Command complete pulse |
| pin_own | output | 1 | Sequencer owns the shared clock pin |
| ant_restore | output | 1 | Pulse: the other function must restore the pin |

## Verification
Every pin event is a fixed number of half-periods after acceptance. Chip select is visible one cycle after the accepting edge, the first clock rise comes 2E later, and each later clock edge comes E after the one before it. `done` coincides with the chip-select fall, or follows it by `WRITE_HOLD` clocks after a write. The bench samples on the falling system-clock edge and timestamps each transition it sees, so it compares intervals against E and `WRITE_HOLD` rather than absolute cycle numbers. Its EEPROM model changes `ee_do` only half a cycle after each observed clock rise, so each bit is stable a full half-period before the sequencer samples it.

// File: rtl/uw_pkg.sv
package uw_pkg;

  localparam int UW_DATA_W   = 16;
  localparam int UW_ADDR_MAX = 8;
  localparam int UW_ADDR_MIN = 6;
  localparam int UW_OPC_W    = 3;
  localparam int UW_FRAME_W  = UW_OPC_W + UW_ADDR_MAX + UW_DATA_W;
  localparam int UW_LEN_W    = $clog2(UW_FRAME_W + 1);

  typedef enum logic [1:0] {
    UW_READ  = 2'd0,
    UW_WRITE = 2'd1,
    UW_WREN  = 2'd2,
    UW_WRDIS = 2'd3
  } uw_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_LO, S_HI, S_TAIL, S_HOLD
  } uw_state_e;

  localparam logic [2:0] OPC_READ  = 3'b110;
  localparam logic [2:0] OPC_WRITE = 3'b101;
  localparam logic [4:0] OPC_WREN  = 5'b10011;
  localparam logic [4:0] OPC_WRDIS = 5'b10000;

  // number of serial clocks in a frame
  function automatic logic [UW_LEN_W-1:0] frame_len(uw_op_e op, logic long_a);
    int n;
    if (op == UW_READ || op == UW_WRITE)
      n = UW_OPC_W + (long_a ? UW_ADDR_MAX : UW_ADDR_MIN) + UW_DATA_W;
    else
      n = 11;
    return UW_LEN_W'(n);
  endfunction

  // frame bits, first bit to send in the top position
  function automatic logic [UW_FRAME_W-1:0] frame_bits(uw_op_e op,
      logic [UW_ADDR_MAX-1:0] addr, logic [UW_DATA_W-1:0] wd, logic long_a);
    logic [UW_FRAME_W-1:0] f;
    f = '0;
    unique case (op)
      UW_READ:  f = long_a ? {OPC_READ, addr, {UW_DATA_W{1'b0}}}
                           : {OPC_READ, addr[UW_ADDR_MIN-1:0], {UW_DATA_W{1'b0}}, 2'b00};
      UW_WRITE: f = long_a ? {OPC_WRITE, addr, wd}
                           : {OPC_WRITE, addr[UW_ADDR_MIN-1:0], wd, 2'b00};
      UW_WREN:  f = {OPC_WREN,  {(UW_FRAME_W-5){1'b0}}};
      UW_WRDIS: f = {OPC_WRDIS, {(UW_FRAME_W-5){1'b0}}};
      default:  f = '0;
    endcase
    return f;
  endfunction

  // half-period after applying the floor
  function automatic int unsigned eff_half(int unsigned div, int unsigned floor_v);
    return (div < floor_v) ? floor_v : div;
  endfunction

endpackage

// File: rtl/uw_prescaler.sv
module uw_prescaler
  import uw_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  assign reload = DIV_W'(eff_half(int'(div), MIN_HALF) - 1);
  assign tick   = !restart && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (restart || cnt == '0) cnt <= reload;
    else                          cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/uw_shift_out.sv
module uw_shift_out #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] frame,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sreg;

  assign msb = sreg[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= frame;
    else if (shift) sreg <= {sreg[W-2:0], 1'b0};
  end
endmodule

// File: rtl/uw_shift_in.sv
module uw_shift_in #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word <= '0;
    else if (sample) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/uw_hold_timer.sv
module uw_hold_timer #(
  parameter int HOLD = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt;
  logic          run;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= CW'(HOLD - 1);
      run <= 1'b1;
    end else if (expire) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/uw_eeprom_seq.sv
module uw_eeprom_seq
  import uw_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int MIN_HALF   = 50,
  parameter int WRITE_HOLD = 500000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [UW_ADDR_MAX-1:0] cmd_addr,
  input  logic [UW_DATA_W-1:0]   cmd_wdata,
  input  logic                   addr_long,
  input  logic [DIV_W-1:0]       half_div,
  output logic                   cmd_ready,
  output logic                   ee_cs,
  output logic                   ee_sk,
  output logic                   ee_di,
  input  logic                   ee_do,
  output logic [UW_DATA_W-1:0]   rd_data,
  output logic                   done,
  output logic                   pin_own,
  output logic                   ant_restore
);
  uw_state_e             state;
  uw_op_e                op_q;
  logic                  long_q;
  logic [DIV_W-1:0]      div_q;
  logic [UW_LEN_W-1:0]   bits_left;

  // named internal events
  logic accept, tick, bit_last, sk_rise_evt, frame_end, hold_start, hold_exp;
  logic finish_evt, so_shift, so_msb;
  logic [DIV_W-1:0]     div_sel;
  logic [UW_DATA_W-1:0] rx_word;

  assign cmd_ready   = (state == S_IDLE);
  assign accept      = cmd_valid && cmd_ready;
  assign div_sel     = cmd_ready ? half_div : div_q;
  assign bit_last    = (bits_left == UW_LEN_W'(1));
  assign sk_rise_evt = (state == S_LO) && tick;
  assign frame_end   = (state == S_HI) && tick && bit_last;
  assign hold_start  = (state == S_TAIL) && tick && (op_q == UW_WRITE);
  assign finish_evt  = ((state == S_TAIL) && tick && (op_q != UW_WRITE)) ||
                       ((state == S_HOLD) && hold_exp);
  assign so_shift    = ((state == S_LEAD) && tick) ||
                       ((state == S_HI) && tick && !bit_last);

  uw_prescaler #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(cmd_ready), .div(div_sel), .tick(tick)
  );

  uw_shift_out #(.W(UW_FRAME_W)) u_txsh (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .frame(frame_bits(uw_op_e'(cmd_op), cmd_addr, cmd_wdata, addr_long)),
    .shift(so_shift), .msb(so_msb)
  );

  uw_shift_in #(.W(UW_DATA_W)) u_rxsh (
    .clk(clk), .rst_n(rst_n), .sample(sk_rise_evt), .din(ee_do), .word(rx_word)
  );

  uw_hold_timer #(.HOLD(WRITE_HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .start(hold_start), .expire(hold_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      op_q        <= UW_READ;
      long_q      <= 1'b0;
      div_q       <= '0;
      bits_left   <= '0;
      ee_cs       <= 1'b0;
      ee_sk       <= 1'b0;
      ee_di       <= 1'b0;
      pin_own     <= 1'b0;
      done        <= 1'b0;
      ant_restore <= 1'b0;
      rd_data     <= '0;
    end else begin
      done        <= 1'b0;
      ant_restore <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          state     <= S_LEAD;
          op_q      <= uw_op_e'(cmd_op);
          long_q    <= addr_long;
          div_q     <= half_div;
          bits_left <= frame_len(uw_op_e'(cmd_op), addr_long);
          ee_cs     <= 1'b1;
          ee_sk     <= 1'b0;
          ee_di     <= 1'b0;
          pin_own   <= 1'b1;
        end
        S_LEAD: if (tick) begin
          ee_di <= so_msb;
          state <= S_LO;
        end
        S_LO: if (tick) begin
          ee_sk <= 1'b1;
          state <= S_HI;
        end
        S_HI: if (tick) begin
          ee_sk     <= 1'b0;
          bits_left <= bits_left - 1'b1;
          if (frame_end) begin
            ee_di <= 1'b0;
            state <= S_TAIL;
          end else begin
            ee_di <= so_msb;
            state <= S_LO;
          end
        end
        S_TAIL: if (tick) begin
          ee_cs <= 1'b0;
          state <= (op_q == UW_WRITE) ? S_HOLD : S_IDLE;
        end
        S_HOLD: if (hold_exp) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (finish_evt) begin
        done        <= 1'b1;
        ant_restore <= 1'b1;
        pin_own     <= 1'b0;
        if (op_q == UW_READ) rd_data <= rx_word;
      end
    end
  end

  logic unused_long;
  assign unused_long = long_q;
endmodule

// File: rtl/uw_eeprom_seq_chk.sv
module uw_eeprom_seq_chk #(
  parameter int MIN_HALF = 50
) (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        cmd_ready,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        ee_di,
  input logic        done,
  input logic        pin_own,
  input logic        ant_restore,
  input logic [15:0] rd_data
);
  assert_sk_inside_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  assert_own_covers_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs |-> pin_own);

  assert_quiet_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ee_cs && !ee_sk && !ee_di && pin_own));

  generate
    if (MIN_HALF >= 2) begin : g_half
      assert_high_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |=> ee_sk);
      assert_low_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ee_sk) && ee_cs) |=> !ee_sk);
    end
  endgenerate

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ant_restore && !pin_own && $past(pin_own) && cmd_ready));

  assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pin_own |-> !cmd_ready);

  assert_rd_only_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);
endmodule

bind uw_eeprom_seq uw_eeprom_seq_chk #(.MIN_HALF(MIN_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_ready(cmd_ready),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .done(done),
  .pin_own(pin_own), .ant_restore(ant_restore), .rd_data(rd_data)
);

// File: tb/uw_eeprom_seq_test.sv
module uw_eeprom_seq_test;
  localparam int HOLD = 300;
  localparam int MINH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_addr = 8'h00;
  logic [15:0] cmd_wdata = 16'h0;
  logic        addr_long = 1'b0;
  logic [7:0]  half_div = 8'd2;
  logic        ee_do = 1'b0;
  logic        cmd_ready, ee_cs, ee_sk, ee_di, done, pin_own, ant_restore;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] exp_rd = 16'h0;

  always #10 clk = ~clk;

  uw_eeprom_seq #(.DIV_W(8), .MIN_HALF(MINH), .WRITE_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .addr_long(addr_long),
    .half_div(half_div), .cmd_ready(cmd_ready), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do), .rd_data(rd_data), .done(done),
    .pin_own(pin_own), .ant_restore(ant_restore)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(int op, bit lg);
    return (op < 2) ? (3 + (lg ? 8 : 6) + 16) : 11;
  endfunction

  // bit k of the result is the k-th bit on the wire
  function automatic logic [31:0] exp_seq(int op, logic [7:0] a, logic [15:0] w, bit lg);
    logic [31:0] v;
    logic [4:0]  opc;
    int ow, n, aw;
    v = '0; n = 0; aw = lg ? 8 : 6;
    case (op)
      0:       begin opc = 5'b00110; ow = 3; end
      1:       begin opc = 5'b00101; ow = 3; end
      2:       begin opc = 5'b10011; ow = 5; end
      default: begin opc = 5'b10000; ow = 5; end
    endcase
    for (int b = ow - 1; b >= 0; b--) begin v[n] = opc[b]; n++; end
    if (op < 2) for (int b = aw - 1; b >= 0; b--) begin v[n] = a[b]; n++; end
    if (op == 1) for (int b = 15; b >= 0; b--) begin v[n] = w[b]; n++; end
    return v;
  endfunction

  function automatic int eff_of(int div);
    return (div < MINH) ? MINH : div;
  endfunction

  task automatic run_cmd(int op, logic [7:0] a, logic [15:0] w, bit lg, int div, bit poke);
    int t, nb, last_edge, cs_fall, done_t, bad_half, eff, hdr, first_gap;
    logic [31:0] cap;
    logic prev_sk, prev_cs, got_restore, got_own, got_ready;
    logic [31:0] exp_bits;
    int len;
    eff = eff_of(div);
    hdr = 3 + (lg ? 8 : 6);
    len = exp_len(op, lg);
    exp_bits = exp_seq(op, a, w, lg);
    cap = '0; nb = 0; last_edge = 0; cs_fall = -1; done_t = -1; bad_half = 0; first_gap = -1;
    got_restore = 0; got_own = 1; got_ready = 0;
    @(negedge clk);
    cmd_op = 2'(op); cmd_addr = a; cmd_wdata = w; addr_long = lg;
    half_div = 8'(div); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    // R2: lines quiet with chip select up one cycle after acceptance
    check(ee_cs && !ee_sk && !ee_di && pin_own && !cmd_ready, "R2", "start state",
          {ee_cs, ee_sk, ee_di, pin_own, cmd_ready}, 5'b10010);
    if (poke) begin
      cmd_valid = 1'b1; cmd_op = 2'd1; cmd_addr = ~a; cmd_wdata = ~w; addr_long = ~lg;
    end
    prev_sk = 1'b0; prev_cs = 1'b1; t = 0;
    while (done_t < 0 && t < 20000) begin
      @(negedge clk);
      t++;
      if (t == 1) cmd_valid = 1'b0;
      if (ee_sk && !prev_sk) begin
        if (nb < 32) cap[nb] = ee_di;
        nb++;
        if (nb == 1) first_gap = t - last_edge;
        else if (t - last_edge != eff) bad_half++;
        last_edge = t;
        if (nb >= hdr && nb < hdr + 16) ee_do = w[15 - (nb - hdr)];
        else ee_do = 1'($urandom);
      end
      if (!ee_sk && prev_sk) begin
        if (t - last_edge != eff) bad_half++;
        last_edge = t;
      end
      if (!ee_cs && prev_cs) begin
        cs_fall = t;
        if (t - last_edge != eff) bad_half++;
      end
      if (done) begin
        done_t = t; got_restore = ant_restore; got_own = pin_own; got_ready = cmd_ready;
      end
      prev_sk = ee_sk; prev_cs = ee_cs;
    end
    check(done_t >= 0, "R10", "done seen", done_t, 1);
    check(first_gap == 2 * eff, "R2", "first clock rise delay", first_gap, 2 * eff);
    check(bad_half == 0, "R7", "half-period mismatches", bad_half, 0);
    check(nb == len, (op == 0) ? "R3" : (op == 1) ? "R4" : "R5", "clock count", nb, len);
    check((cap & ((32'd1 << len) - 1)) == exp_bits,
          (op == 0) ? "R3" : (op == 1) ? "R4" : "R5", lg ? "frame bits" : "frame bits R6",
          cap, exp_bits);
    if (op == 1) check(done_t - cs_fall == HOLD, "R9", "write hold", done_t - cs_fall, HOLD);
    else         check(done_t == cs_fall, "R9", "done vs cs fall", done_t - cs_fall, 0);
    check(got_restore && !got_own && got_ready, "R10", "release flags",
          {got_restore, got_own, got_ready}, 3'b101);
    if (op == 0) begin
      exp_rd = w;
      check(rd_data == exp_rd, "R8", "read word", rd_data, exp_rd);
    end else begin
      check(rd_data == exp_rd, "R11", "rd_data kept", rd_data, exp_rd);
    end
    repeat (3) @(negedge clk);
    check(!done && !ee_cs && cmd_ready && !pin_own, poke ? "R12" : "R10", "idle after done",
          {done, ee_cs, cmd_ready, pin_own}, 4'b0010);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset values
    check(!ee_cs && !ee_sk && !ee_di && !pin_own && !done && !ant_restore && cmd_ready
          && rd_data == 16'h0, "R1", "reset state",
          {ee_cs, ee_sk, ee_di, pin_own, done, ant_restore, cmd_ready, rd_data}, 23'h010000);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ee_cs && cmd_ready && !pin_own, "R1", "after release", {ee_cs, cmd_ready, pin_own}, 3'b010);

    run_cmd(0, 8'hA5, 16'hBEEF, 1, 3, 0);   // R3 R8 long address
    run_cmd(0, 8'hFF, 16'h1234, 0, 2, 0);   // R6 upper bits dropped
    run_cmd(1, 8'h3C, 16'hC3A5, 1, 2, 0);   // R4 R9
    run_cmd(2, 8'h77, 16'hFFFF, 1, 4, 0);   // R5 enable
    run_cmd(3, 8'h11, 16'h0F0F, 0, 2, 0);   // R5 disable
    run_cmd(0, 8'h01, 16'h8001, 1, 1, 0);   // R7 floor
    run_cmd(1, 8'hC0, 16'h5A5A, 0, 0, 0);   // R7 floor, R6
    run_cmd(0, 8'h5A, 16'h7FFE, 1, 2, 1);   // R12 request while busy
    run_cmd(2, 8'h00, 16'h0000, 0, 3, 1);   // R12

    for (int i = 0; i < 24; i++) begin
      run_cmd(int'($urandom_range(3, 0)), 8'($urandom), 16'($urandom),
              1'($urandom), int'($urandom_range(5, 0)), 1'($urandom_range(3, 0) == 0));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule